// File: doc/BRIEF.md
# Shared-address serial data buffer with status flags

This block sits between a processor bus and the two shift registers of a serial port. A single data address serves both directions. A bus write lands in a one-entry transmit holding buffer. A bus read returns the oldest character of a two-entry receive queue and removes it from the queue. The holding buffer passes its character to the transmit shifter through a load handshake. Received characters arrive from the receive shifter on a push strobe.

Characters may be 5, 6, 7 or 8 bits wide. Unused upper bits are cleared on both paths. The block keeps four flags:
- receive-complete,
- transmit-complete,
- data-register-empty,
- a sticky overrun flag.

Three of the flags each drive an interrupt request, which is gated by its own enable input. Bit timing, baud generation, parity and framing checks belong to the shifters and are outside this block.

Top module: `sio_databuf`

## Requirements
- R1: After reset, dre_flag is 1, and rxc_flag, txc_flag, ovr_flag and sh_load are 0.
- R2: A bus_wr while dre_flag is 1 stores the masked bus_wdata in the holding buffer. dre_flag reads 0 from the next cycle onward, until a load takes place.
- R3: A bus_wr while dre_flag is 0 has no effect. The character later handed to the shifter is the one stored before.
- R4: sh_load is high in the same cycle as tx_en=1, a full holding buffer and sh_ready=1. In that cycle sh_load_data carries the stored character. dre_flag is 1 from the next cycle. While tx_en=0, sh_load stays 0.
- R5: char_bits selects the character width: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Written data has its bits above the width cleared before it is stored.
- R6: A received character has its bits above the width selected by char_bits cleared before it is queued.
- R7: The receive queue returns characters oldest first. bus_rdata shows the oldest entry in the same cycle, and reads 0 while the queue is empty. A bus_rd pops one entry. rxc_flag is 1 exactly while the queue is not empty.
- R8: An rx_push while the queue holds two entries and no bus_rd is active is dropped, and it sets ovr_flag. ovr_flag stays set until a bus_rd pops an entry.
- R9: While rx_en=0 the queue is emptied, ovr_flag is cleared, and rx_push is ignored.
- R10: txc_flag sets on the cycle after sh_frame_done while the holding buffer is empty. A sh_frame_done while the buffer is full leaves txc_flag unchanged. If a set and a clear fall in the same cycle, the set wins.
- R11: txc_flag clears on the cycle after txc_w1c=1 or txc_ack=1.
- R12: Each request line is its flag ANDed with its enable: irq_rxc is rxc_flag & ie_rxc, irq_txc is txc_flag & ie_txc, and irq_dre is dre_flag & ie_dre.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe to the data address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe to the data address; pops the queue |
| bus_rdata | output | 8 | Oldest queued character, 0 when the queue is empty |
| char_bits | input | 2 | Character width select (0 to 3 gives 5 to 8 bits) |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable; 0 flushes the queue |
| sh_ready | input | 1 | Transmit shifter is empty |
| sh_load | output | 1 | Load pulse to the transmit shifter |
| sh_load_data | output | 8 | Character handed to the shifter |
| sh_frame_done | input | 1 | Transmit shifter finished a frame |
| rx_push | input | 1 | Receive shifter has a character |
| rx_data | input | 8 | Received character |
| txc_w1c | input | 1 | Software write of one to the transmit-complete bit |
| txc_ack | input | 1 | Transmit-complete interrupt acknowledge |
| ie_rxc | input | 1 | Receive-complete interrupt enable |
| ie_txc | input | 1 | Transmit-complete interrupt enable |
| ie_dre | input | 1 | Data-register-empty interrupt enable |
| rxc_flag | output | 1 | Receive queue not empty |
| txc_flag | output | 1 | Transmit complete |
| dre_flag | output | 1 | Holding buffer can accept data |
| ovr_flag | output | 1 | Sticky receive overrun |
| irq_rxc | output | 1 | Receive-complete request |
| irq_txc | output | 1 | Transmit-complete request |
| irq_dre | output | 1 | Data-register-empty request |

## Verification
The results fall due at two times.
- Same cycle: bus_rdata, sh_load, sh_load_data and the request lines are combinational. The bench checks them after driving the inputs and before the next rising edge.
- Next cycle: dre_flag, rxc_flag, txc_flag and ovr_flag change one cycle after the strobe that moves them.

Every strobe is held for exactly one clock. The bench drives it one time unit after a rising edge, and checks the registered flags one time unit after the edge that captures it. Inputs that are meant to be ignored are followed by a read of the queue or a load. This shows at the ports that the stored contents did not change.

// File: rtl/sio_databuf_pkg.sv
// Package: shared widths and the character-width mask for the serial data buffer.
// Assumes an 8-bit bus and width codes 0..3 meaning 5..8 data bits.
package sio_databuf_pkg;
    localparam int DATA_W = 8;
    localparam int SEL_W  = 2;

    // Mask keeping only the bits of the selected character width.
    function automatic logic [DATA_W-1:0] char_mask(input logic [SEL_W-1:0] sel);
        logic [DATA_W-1:0] m;
        m = {DATA_W{1'b1}} >> (2'd3 - sel);
        return m;
    endfunction
endpackage

// File: rtl/sio_txhold.sv
// Module: one-entry transmit holding buffer and transmit-complete flag.
// Accepts a bus write only when empty, hands its content to the shifter when
// the transmitter is enabled and the shifter reports empty. Sets the complete
// flag when a frame ends with nothing held. Assumes single-cycle strobes.
module sio_txhold
    import sio_databuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SEL_W-1:0]  char_bits,
    input  logic              tx_en,
    input  logic              sh_ready,
    input  logic              sh_frame_done,
    input  logic              txc_w1c,
    input  logic              txc_ack,
    output logic              sh_load,
    output logic [DATA_W-1:0] sh_load_data,
    output logic              dre,
    output logic              txc
);
    logic              full_q;
    logic [DATA_W-1:0] data_q;
    logic              accept;
    logic              txc_set;
    logic              txc_clr;

    // Decode of the write acceptance, the load handshake and the flag events.
    always_comb begin
        accept       = wr && !full_q;
        sh_load      = tx_en && full_q && sh_ready;
        sh_load_data = data_q;
        txc_set      = sh_frame_done && !full_q;
        txc_clr      = txc_w1c || txc_ack;
        dre          = !full_q;
    end

    // Holding-buffer occupancy and content.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (accept) begin
            full_q <= 1'b1;
            data_q <= wdata & char_mask(char_bits);
        end else if (sh_load) begin
            full_q <= 1'b0;
        end
    end

    // Transmit-complete flag, a set in the same cycle beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       txc <= 1'b0;
        else if (txc_set) txc <= 1'b1;
        else if (txc_clr) txc <= 1'b0;
    end

    // R3: a write to a full buffer leaves the stored character unchanged
    a_r3_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !dre) |=> $stable(sh_load_data));

    // R4: a load frees the buffer for the next cycle
    a_r4_load_frees: assert property (@(posedge clk) disable iff (!rst_n)
        sh_load |=> dre);

    // R2: an accepted write makes the buffer full
    a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && dre) |=> !dre);

    // R11: a clear without a concurrent set leaves the flag low
    a_r11_txc_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((txc_w1c || txc_ack) && !(sh_frame_done && dre)) |=> !txc);
endmodule

// File: rtl/sio_rxfifo.sv
// Module: receive queue of DEPTH entries with overrun detection.
// Pops on every bus read that finds data, drops a push that finds it full
// (unless a read frees space in the same cycle) and raises a sticky overrun.
// Receiver disable flushes everything. Head is presented combinationally.
module sio_rxfifo
    import sio_databuf_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic [SEL_W-1:0]  char_bits,
    input  logic              rd,
    output logic [DATA_W-1:0] head,
    output logic              not_empty,
    output logic              ovr
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wp_q, rp_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              pop, take, drop;

    // Pop, accept and drop decisions for this cycle.
    always_comb begin
        pop       = rd && (cnt_q != '0);
        take      = rx_en && push && ((cnt_q != FULL_CNT) || pop);
        drop      = rx_en && push && (cnt_q == FULL_CNT) && !pop;
        not_empty = (cnt_q != '0);
        head      = not_empty ? mem[rp_q] : '0;
    end

    // Storage array, written at the write pointer on an accepted push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (take) begin
            mem[wp_q] <= din & char_mask(char_bits);
        end
    end

    // Pointers and occupancy count, with flush on receiver disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (take) wp_q <= (wp_q == LAST_PTR) ? '0 : wp_q + 1'b1;
            if (pop)  rp_q <= (rp_q == LAST_PTR) ? '0 : rp_q + 1'b1;
            if (take && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !take) cnt_q <= cnt_q - 1'b1;
        end
    end

    // Sticky overrun, cleared by a pop or a flush.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en) ovr <= 1'b0;
        else if (drop)        ovr <= 1'b1;
        else if (pop)         ovr <= 1'b0;
    end

    // R8: a dropped push keeps the queue full and raises overrun
    a_r8_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && push && !rd && cnt_q == FULL_CNT) |=> (ovr && cnt_q == FULL_CNT));

    // R9: disabling the receiver empties the queue
    a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!not_empty && !ovr));

    // R7: occupancy never exceeds the depth
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);

    // R7: a read of a single entry empties the queue when nothing is pushed
    a_r7_pop_last: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rd && cnt_q == CNT_W'(1) && !push) |=> !not_empty);
endmodule

// File: rtl/sio_irqgate.sv
// Module: gates each status flag with its enable to form a request line.
// Assumes flags and enables are level signals; output is combinational.
module sio_irqgate #(
    parameter int N = 3
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] enables,
    output logic [N-1:0] reqs
);
    for (genvar g = 0; g < N; g++) begin : g_gate
        // One AND gate per request line.
        always_comb reqs[g] = flags[g] & enables[g];
    end
endmodule

// File: rtl/sio_databuf.sv
// Module: top of the shared-address serial data buffer. Routes the single
// data address to the transmit holding buffer (write) and the receive queue
// (read), and exposes the status flags and gated requests.
// Assumes bus strobes last one cycle and shifters follow the handshakes.
module sio_databuf
    import sio_databuf_pkg::*;
#(
    parameter int RX_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [SEL_W-1:0]  char_bits,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              sh_ready,
    output logic              sh_load,
    output logic [DATA_W-1:0] sh_load_data,
    input  logic              sh_frame_done,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              txc_w1c,
    input  logic              txc_ack,
    input  logic              ie_rxc,
    input  logic              ie_txc,
    input  logic              ie_dre,
    output logic              rxc_flag,
    output logic              txc_flag,
    output logic              dre_flag,
    output logic              ovr_flag,
    output logic              irq_rxc,
    output logic              irq_txc,
    output logic              irq_dre
);
    localparam int NREQ = 3;
    logic [NREQ-1:0] req_vec;

    sio_txhold u_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr            (bus_wr),
        .wdata         (bus_wdata),
        .char_bits     (char_bits),
        .tx_en         (tx_en),
        .sh_ready      (sh_ready),
        .sh_frame_done (sh_frame_done),
        .txc_w1c       (txc_w1c),
        .txc_ack       (txc_ack),
        .sh_load       (sh_load),
        .sh_load_data  (sh_load_data),
        .dre           (dre_flag),
        .txc           (txc_flag)
    );

    sio_rxfifo #(.DEPTH(RX_DEPTH)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .push      (rx_push),
        .din       (rx_data),
        .char_bits (char_bits),
        .rd        (bus_rd),
        .head      (bus_rdata),
        .not_empty (rxc_flag),
        .ovr       (ovr_flag)
    );

    sio_irqgate #(.N(NREQ)) u_irq (
        .flags   ({dre_flag, txc_flag, rxc_flag}),
        .enables ({ie_dre, ie_txc, ie_rxc}),
        .reqs    (req_vec)
    );

    // Split the gated request vector onto the named outputs.
    always_comb begin
        irq_rxc = req_vec[0];
        irq_txc = req_vec[1];
        irq_dre = req_vec[2];
    end

    // R1: flags hold their reset values on the first cycle after reset
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (dre_flag && !rxc_flag && !txc_flag && !ovr_flag));
endmodule

// File: tb/sio_databuf_bench.sv
module sio_databuf_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic [1:0] char_bits = 2'd3;
    logic       tx_en = 0, rx_en = 0, sh_ready = 0, sh_frame_done = 0;
    logic       sh_load;
    logic [7:0] sh_load_data;
    logic       rx_push = 0;
    logic [7:0] rx_data = 0;
    logic       txc_w1c = 0, txc_ack = 0, ie_rxc = 0, ie_txc = 0, ie_dre = 0;
    logic       rxc_flag, txc_flag, dre_flag, ovr_flag, irq_rxc, irq_txc, irq_dre;

    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    sio_databuf u_sio_databuf (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Advance to one time unit after the next rising edge.
    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [7:0] d);
        bus_wdata = d; bus_wr = 1; tick(); bus_wr = 0;
    endtask

    task automatic push(logic [7:0] d);
        rx_data = d; rx_push = 1; tick(); rx_push = 0;
    endtask

    task automatic rd(string req, logic [7:0] exp);
        check(req, bus_rdata, exp);
        bus_rd = 1; tick(); bus_rd = 0;
    endtask

    // Enable the shifter for one cycle and check what is loaded.
    task automatic load(string req, logic [7:0] exp);
        sh_ready = 1; #0.5;
        check(req, sh_load, 1);
        check(req, sh_load_data, exp);
        tick(); sh_ready = 0;
        check(req, dre_flag, 1);
    endtask

    task automatic t_reset();
        check("R1 dre", dre_flag, 1);
        check("R1 rxc", rxc_flag, 0);
        check("R1 txc", txc_flag, 0);
        check("R1 ovr", ovr_flag, 0);
        check("R1 load", sh_load, 0);
    endtask

    task automatic t_tx();
        char_bits = 2'd0;
        wr(8'hFF);
        check("R2 dre low", dre_flag, 0);
        tx_en = 0; sh_ready = 1; #0.5;
        check("R4 no load when disabled", sh_load, 0);
        sh_ready = 0; tx_en = 1;
        load("R5 5-bit mask", 8'h1F);
        char_bits = 2'd3;
        wr(8'hAA);
        wr(8'h55);
        check("R3 still full", dre_flag, 0);
        load("R3 first kept", 8'hAA);
        char_bits = 2'd1;
        wr(8'hFF);
        load("R5 6-bit mask", 8'h3F);
        char_bits = 2'd3;
    endtask

    task automatic t_txc();
        sh_frame_done = 1; tick(); sh_frame_done = 0;
        check("R10 set", txc_flag, 1);
        txc_w1c = 1; tick(); txc_w1c = 0;
        check("R11 w1c", txc_flag, 0);
        sh_frame_done = 1; tick(); sh_frame_done = 0;
        txc_ack = 1; tick(); txc_ack = 0;
        check("R11 ack", txc_flag, 0);
        tx_en = 0;
        wr(8'h11);
        sh_frame_done = 1; tick(); sh_frame_done = 0;
        check("R10 no set when full", txc_flag, 0);
        tx_en = 1;
        load("R4 load", 8'h11);
        sh_frame_done = 1; txc_w1c = 1; tick(); sh_frame_done = 0; txc_w1c = 0;
        check("R10 set wins", txc_flag, 1);
    endtask

    task automatic t_rx();
        rx_en = 1; tick();
        check("R7 empty rdata", bus_rdata, 0);
        char_bits = 2'd2;
        push(8'hFF);
        check("R7 rxc", rxc_flag, 1);
        rd("R6 7-bit mask", 8'h7F);
        check("R7 rxc clear", rxc_flag, 0);
        char_bits = 2'd3;
        push(8'hA1);
        push(8'hB2);
        push(8'hC3);
        check("R8 ovr", ovr_flag, 1);
        rd("R8 first", 8'hA1);
        check("R8 ovr cleared", ovr_flag, 0);
        rd("R7 second", 8'hB2);
        check("R8 dropped", rxc_flag, 0);
        push(8'h44);
        push(8'h45);
        push(8'h46);
        rx_en = 0; tick();
        check("R9 flushed", rxc_flag, 0);
        check("R9 ovr", ovr_flag, 0);
        push(8'h77);
        check("R9 push ignored", rxc_flag, 0);
        rx_en = 1; tick();
        check("R9 still empty", bus_rdata, 0);
    endtask

    task automatic t_irq();
        push(8'h01);
        ie_rxc = 1; ie_txc = 0; ie_dre = 1; #0.5;
        check("R12 rxc", irq_rxc, 1);
        check("R12 txc masked", irq_txc, 0);
        check("R12 dre", irq_dre, 1);
        ie_rxc = 0; ie_txc = 1; ie_dre = 0; #0.5;
        check("R12 rxc masked", irq_rxc, 0);
        check("R12 txc", irq_txc, txc_flag);
        check("R12 dre masked", irq_dre, 0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1; tick();
        t_reset();
        t_tx();
        t_txc();
        t_rx();
        t_irq();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #50000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule